// File: doc/BRIEF.md
# Multi-profile SPI master

This block is a serial-peripheral-interface master that serves several slave devices through one shift engine. Each slave owns a profile with its own clock divider, transfer length and edge choices. A transaction names the target slave and carries the write word. The engine latches that slave's profile and runs the transfer. It then returns the read word and pulses done. Only one transfer is in flight at a time. Two copies of the block, one per radio, run side by side with no shared state.

The serial clock, data-out, data-in and every chip-select are routed to general-purpose pins through a programmable map. The serial clock idles low and chip-selects are active low. The request side uses valid/ready. A request is accepted on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low for the whole transfer. Holding `req_valid` high while `req_ready` is low does not queue the request. Instead it raises `req_err` one cycle later, once for each such cycle. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse that the consumer must take.

Top module: `spi_prof_master`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, every chip-select pin drives 1 and the serial-clock pin drives 0.
- R2: A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is 0 from the next cycle until the transfer ends.
- R3: For each cycle in which `req_valid` is high while `req_ready` is low, `req_err` is 1 in the following cycle and 0 otherwise. Such a request starts nothing and leaves the active transfer unchanged.
- R4: The chip-select of the named slave goes low in the cycle after acceptance. At most one chip-select is low at any time.
- R5: With divider D, every serial-clock half-period lasts D+1 system clocks. The first rising edge comes D+1 clocks after chip-select falls. Chip-select rises D+1 clocks after the last falling edge.
- R6: A transfer with length L (1..32) produces exactly 2L serial-clock edges.
- R7: Write data is sent MSB first from bit L-1 down to bit 0. With the launch bit at 0, data-out changes on falling edges and the first bit is present from chip-select assertion. With the launch bit at 1, data-out changes on every rising edge except the first.
- R8: With the capture bit at 0, data-in is sampled on rising edges. With it at 1, data-in is sampled on falling edges. The read word is right-aligned with its upper bits zero.
- R9: `rsp_valid` is high for exactly one cycle, in the cycle where chip-select rises. `rsp_rdata` changes only in that cycle.
- R10: Map signal indices are 0 serial clock, 1 data-out, 2 data-in, and 3+k chip-select k. After reset index i maps to pin i. Each output signal drives its mapped pin with output-enable 1. Unmapped pins have output-enable 0 and drive 0. When two outputs share a pin, the lower index wins. Data-in is read from the pin mapped to index 2.
- R11: Profile writes during a transfer do not affect it. They apply to transfers accepted later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Profile write strobe |
| cfg_slave | input | $clog2(NUM_SLV) | Profile being written |
| cfg_div | input | 16 | Half-period divider (half-period = value+1 clocks) |
| cfg_len | input | 6 | Transfer length in bits, 1..32 |
| cfg_launch_rise | input | 1 | 1: data-out changes on rising edges |
| cfg_cap_fall | input | 1 | 1: data-in sampled on falling edges |
| map_we | input | 1 | Pin map write strobe |
| map_sig | input | $clog2(NUM_SLV+3) | Signal index being remapped |
| map_pin | input | $clog2(NUM_PINS) | Target pin |
| req_valid | input | 1 | Transaction request valid |
| req_ready | output | 1 | Engine idle, request can be accepted |
| req_slave | input | $clog2(NUM_SLV) | Target slave |
| req_wdata | input | 32 | Write word, right-aligned |
| req_err | output | 1 | Request presented while busy |
| rsp_valid | output | 1 | Done pulse |
| rsp_rdata | output | 32 | Read word, right-aligned |
| gpio_in | input | NUM_PINS | Pin input levels |
| gpio_out | output | NUM_PINS | Pin output levels |
| gpio_oe | output | NUM_PINS | Pin output enables |

## Verification
The assertions assume that a programmed length lies between 1 and 32. They also assume that the pin map is rewritten only while the engine is idle, and that no two chip-selects are folded onto one pin. The bench keeps within these limits: every profile it writes has a legal length, and every map change happens between transfers. The one shared-pin case it builds pairs a chip-select with the serial clock, only to observe the priority rule while idle. Profile rewrites are made on purpose during a transfer, since the design must tolerate them.

// File: rtl/spi_prof_pkg.sv
package spi_prof_pkg;
  parameter int DIV_W  = 16;
  parameter int LEN_W  = 6;
  parameter int DATA_W = 32;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [LEN_W-1:0] len;
    logic             launch_rise;
    logic             cap_fall;
  } prof_t;

  localparam prof_t PROF_RESET = '{div: '0, len: LEN_W'(8), launch_rise: 1'b0, cap_fall: 1'b0};
endpackage

// File: rtl/spi_prof_bank.sv
module spi_prof_bank
  import spi_prof_pkg::*;
#(
  parameter int NUM_SLV = 4,
  localparam int SEL_W = $clog2(NUM_SLV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  prof_t            wr_prof,
  input  logic [SEL_W-1:0] rd_sel,
  output prof_t            rd_prof
);
  prof_t prof_q [NUM_SLV];

  for (genvar g = 0; g < NUM_SLV; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        prof_q[g] <= PROF_RESET;
      else if (wr_en && wr_sel == SEL_W'(g))
        prof_q[g] <= wr_prof;
    end
  end

  assign rd_prof = prof_q[rd_sel];
endmodule

// File: rtl/spi_prof_core.sv
module spi_prof_core
  import spi_prof_pkg::*;
#(
  parameter int NUM_SLV = 4,
  localparam int SEL_W = $clog2(NUM_SLV)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [SEL_W-1:0]   req_slave,
  input  logic [DATA_W-1:0]  req_wdata,
  input  prof_t              sel_prof,
  output logic               req_err,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  input  logic               miso,
  output logic               sclk,
  output logic               mosi,
  output logic [NUM_SLV-1:0] cs_n
);
  typedef enum logic {S_IDLE, S_RUN} state_t;

  state_t            state;
  prof_t             act;
  logic [DIV_W-1:0]  hcnt;
  logic [LEN_W:0]    ecnt;
  logic [DATA_W-1:0] tx_sh, rx_sh;
  logic              tick, edge_rise, last_step, do_shift, do_capture;

  assign tick       = (state == S_RUN) && (hcnt == act.div);
  assign edge_rise  = ~ecnt[0];
  assign last_step  = (ecnt == {act.len, 1'b0});
  assign do_shift   = act.launch_rise ? (edge_rise && ecnt != '0) : !edge_rise;
  assign do_capture = act.cap_fall ? !edge_rise : edge_rise;
  assign req_ready  = (state == S_IDLE);
  assign mosi       = tx_sh[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      act       <= PROF_RESET;
      hcnt      <= '0;
      ecnt      <= '0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      sclk      <= 1'b0;
      cs_n      <= '1;
      req_err   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      req_err   <= req_valid && (state == S_RUN);
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            act   <= sel_prof;
            tx_sh <= req_wdata << (DATA_W - int'(sel_prof.len));
            rx_sh <= '0;
            hcnt  <= '0;
            ecnt  <= '0;
            for (int k = 0; k < NUM_SLV; k++)
              cs_n[k] <= (req_slave != SEL_W'(k));
            state <= S_RUN;
          end
        end
        S_RUN: begin
          if (tick) begin
            hcnt <= '0;
            if (last_step) begin
              cs_n      <= '1;
              rsp_valid <= 1'b1;
              rsp_rdata <= rx_sh;
              state     <= S_IDLE;
            end else begin
              sclk <= edge_rise;
              ecnt <= ecnt + 1'b1;
              if (do_shift)   tx_sh <= tx_sh << 1;
              if (do_capture) rx_sh <= {rx_sh[DATA_W-2:0], miso};
            end
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_pin_router.sv
module spi_pin_router #(
  parameter int NUM_SLV  = 4,
  parameter int NUM_PINS = 16,
  localparam int NSIG  = NUM_SLV + 3,
  localparam int SIG_W = $clog2(NSIG),
  localparam int PIN_W = $clog2(NUM_PINS),
  localparam int MISO_IDX = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                map_we,
  input  logic [SIG_W-1:0]    map_sig,
  input  logic [PIN_W-1:0]    map_pin,
  input  logic                sclk,
  input  logic                mosi,
  input  logic [NUM_SLV-1:0]  cs_n,
  output logic                miso,
  input  logic [NUM_PINS-1:0] gpio_in,
  output logic [NUM_PINS-1:0] gpio_out,
  output logic [NUM_PINS-1:0] gpio_oe
);
  logic [PIN_W-1:0] map_q [NSIG];
  logic [NSIG-1:0]  sig_val;

  for (genvar g = 0; g < NSIG; g++) begin : g_map
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        map_q[g] <= PIN_W'(g);
      else if (map_we && map_sig == SIG_W'(g))
        map_q[g] <= map_pin;
    end
  end

  assign sig_val = {cs_n, 1'b0, mosi, sclk};

  always_comb begin
    gpio_out = '0;
    gpio_oe  = '0;
    for (int s = NSIG - 1; s >= 0; s--) begin
      if (s != MISO_IDX) begin
        gpio_out[map_q[s]] = sig_val[s];
        gpio_oe[map_q[s]]  = 1'b1;
      end
    end
  end

  assign miso = gpio_in[map_q[MISO_IDX]];
endmodule

// File: rtl/spi_prof_master.sv
module spi_prof_master
  import spi_prof_pkg::*;
#(
  parameter int NUM_SLV  = 4,
  parameter int NUM_PINS = 16,
  localparam int SEL_W = $clog2(NUM_SLV),
  localparam int SIG_W = $clog2(NUM_SLV + 3),
  localparam int PIN_W = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [SEL_W-1:0]    cfg_slave,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic                cfg_launch_rise,
  input  logic                cfg_cap_fall,
  input  logic                map_we,
  input  logic [SIG_W-1:0]    map_sig,
  input  logic [PIN_W-1:0]    map_pin,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [SEL_W-1:0]    req_slave,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                req_err,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  input  logic [NUM_PINS-1:0] gpio_in,
  output logic [NUM_PINS-1:0] gpio_out,
  output logic [NUM_PINS-1:0] gpio_oe
);
  prof_t              wr_prof, sel_prof;
  logic               sclk, mosi, miso;
  logic [NUM_SLV-1:0] cs_n;

  assign wr_prof = '{div: cfg_div, len: cfg_len, launch_rise: cfg_launch_rise, cap_fall: cfg_cap_fall};

  spi_prof_bank #(.NUM_SLV(NUM_SLV)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_sel(cfg_slave), .wr_prof(wr_prof),
    .rd_sel(req_slave), .rd_prof(sel_prof)
  );

  spi_prof_core #(.NUM_SLV(NUM_SLV)) u_core (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_slave(req_slave),
    .req_wdata(req_wdata), .sel_prof(sel_prof), .req_err(req_err),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
  );

  spi_pin_router #(.NUM_SLV(NUM_SLV), .NUM_PINS(NUM_PINS)) u_router (
    .clk(clk), .rst_n(rst_n),
    .map_we(map_we), .map_sig(map_sig), .map_pin(map_pin),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(miso),
    .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe)
  );
endmodule

// File: rtl/spi_prof_master_chk.sv
module spi_prof_master_chk
  import spi_prof_pkg::*;
#(
  parameter int NUM_SLV = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_err,
  input logic               rsp_valid,
  input logic [DATA_W-1:0]  rsp_rdata,
  input logic [NUM_SLV-1:0] cs_n
);
  assert_accept_drops_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_err_when_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_err);

  assert_no_spurious_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_ready) |=> !req_err);

  assert_single_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  assert_idle_deselected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (&cs_n));

  assert_done_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_done_ends_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (req_ready && $past(!req_ready)));

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> $stable(rsp_rdata));
endmodule

bind spi_prof_master spi_prof_master_chk #(.NUM_SLV(NUM_SLV)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_err(req_err), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .cs_n(cs_n)
);

// File: tb/spi_prof_master_tb.sv
module spi_prof_master_tb;
  localparam int NUM_SLV  = 4;
  localparam int NUM_PINS = 16;
  localparam int NSIG     = NUM_SLV + 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_slave = '0;
  logic [15:0] cfg_div = '0;
  logic [5:0]  cfg_len = '0;
  logic        cfg_launch_rise = 1'b0, cfg_cap_fall = 1'b0;
  logic        map_we = 1'b0;
  logic [2:0]  map_sig = '0;
  logic [3:0]  map_pin = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_slave = '0;
  logic [31:0] req_wdata = '0;
  logic        req_err, rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NUM_PINS-1:0] gpio_in = '0;
  logic [NUM_PINS-1:0] gpio_out, gpio_oe;

  always #5 clk = ~clk;

  spi_prof_master #(.NUM_SLV(NUM_SLV), .NUM_PINS(NUM_PINS)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_slave(cfg_slave), .cfg_div(cfg_div), .cfg_len(cfg_len),
    .cfg_launch_rise(cfg_launch_rise), .cfg_cap_fall(cfg_cap_fall),
    .map_we(map_we), .map_sig(map_sig), .map_pin(map_pin),
    .req_valid(req_valid), .req_ready(req_ready), .req_slave(req_slave),
    .req_wdata(req_wdata), .req_err(req_err),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] low_mask(int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction

  typedef struct {
    int          slave;
    logic [31:0] wdata;
    logic [31:0] sdata;
    int          len;
    int          div;
    bit          lr;
    bit          cf;
  } exp_t;

  exp_t q[$];
  int   b_pin [NSIG];
  int   p_div [NUM_SLV];
  int   p_len [NUM_SLV];
  bit   p_lr  [NUM_SLV];
  bit   p_cf  [NUM_SLV];

  // slave model and scoreboard monitor
  int          cyc = 0, last_cyc = 0, edges = 0, bad_iv = 0, midx = 0;
  bit          in_xfer = 0, prev_sclk = 0;
  logic [31:0] macc = '0;
  exp_t        cur;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!in_xfer) begin
        if (q.size() > 0) begin
          cur = q[0];
          if (gpio_out[b_pin[3 + cur.slave]] == 1'b0) begin
            in_xfer = 1; last_cyc = cyc; edges = 0; bad_iv = 0;
            macc = '0; midx = 0; prev_sclk = gpio_out[b_pin[0]];
          end
        end
      end else begin
        if (gpio_out[b_pin[0]] != prev_sclk) begin
          bit rising;
          rising = gpio_out[b_pin[0]];
          if (cyc - last_cyc != cur.div + 1) bad_iv++;
          last_cyc = cyc;
          edges++;
          if (rising != cur.lr) macc = {macc[30:0], gpio_out[b_pin[1]]};
          if (!cur.cf && !rising) midx++;
          if (cur.cf && rising && edges > 1) midx++;
          prev_sclk = rising;
        end
        if (gpio_out[b_pin[3 + cur.slave]] == 1'b1) begin
          if (cyc - last_cyc != cur.div + 1) bad_iv++;
          check(bad_iv == 0, "R5", "half-period/lead/tail violations", bad_iv, 0);
          check(edges == 2 * cur.len, "R6", "sclk edge count", edges, 2 * cur.len);
          check(macc == (cur.wdata & low_mask(cur.len)), "R7", "mosi word", macc,
                cur.wdata & low_mask(cur.len));
          in_xfer = 0;
        end
      end
      gpio_in = '0;
      if (in_xfer && midx < cur.len) gpio_in[b_pin[2]] = cur.sdata[cur.len - 1 - midx];
      if (rsp_valid) begin
        if (q.size() == 0) begin
          check(0, "R9", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(rsp_rdata == (e.sdata & low_mask(e.len)), "R8", "read word", rsp_rdata,
                e.sdata & low_mask(e.len));
          check(in_xfer == 0, "R9", "done coincides with cs rise", in_xfer, 0);
        end
      end
    end
  end

  task automatic set_prof(int s, int div, int len, bit lr, bit cf);
    @(negedge clk);
    cfg_we = 1; cfg_slave = 2'(s); cfg_div = 16'(div); cfg_len = 6'(len);
    cfg_launch_rise = lr; cfg_cap_fall = cf;
    @(negedge clk);
    cfg_we = 0;
    p_div[s] = div; p_len[s] = len; p_lr[s] = lr; p_cf[s] = cf;
  endtask

  task automatic set_map(int sig, int pin);
    @(negedge clk);
    map_we = 1; map_sig = 3'(sig); map_pin = 4'(pin);
    @(negedge clk);
    map_we = 0;
    b_pin[sig] = pin;
  endtask

  task automatic wait_done();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // driver: poke=1 presents a request while busy, recfg=1 rewrites the profile mid-transfer
  task automatic send(int s, logic [31:0] wd, logic [31:0] sd, bit poke, bit recfg);
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    e.slave = s; e.wdata = wd; e.sdata = sd; e.len = p_len[s]; e.div = p_div[s];
    e.lr = p_lr[s]; e.cf = p_cf[s];
    q.push_back(e);
    req_valid = 1; req_slave = 2'(s); req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    check(req_ready == 0, "R2", "ready after accept", req_ready, 0);
    check(gpio_out[b_pin[3 + s]] == 0, "R4", "selected cs low", gpio_out[b_pin[3 + s]], 0);
    if (poke) begin
      req_valid = 1; req_slave = 2'((s + 1) % NUM_SLV); req_wdata = ~wd;
      @(negedge clk);
      req_valid = 0;
      check(req_err == 1, "R3", "err while busy", req_err, 1);
      @(negedge clk);
      check(req_err == 0, "R3", "err clears", req_err, 0);
      check(gpio_out[b_pin[3 + (s + 1) % NUM_SLV]] == 1, "R3", "rejected slave cs stays high",
            gpio_out[b_pin[3 + (s + 1) % NUM_SLV]], 1);
    end
    if (recfg) set_prof(s, p_div[s] + 2, 5, ~p_lr[s], ~p_cf[s]);
    wait_done();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "WDOG", "watchdog expired", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NSIG; i++) b_pin[i] = i;
    for (int s = 0; s < NUM_SLV; s++) begin
      p_div[s] = 0; p_len[s] = 8; p_lr[s] = 0; p_cf[s] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1, "R1", "ready", req_ready, 1);
    check(rsp_valid == 0, "R1", "done", rsp_valid, 0);
    check(gpio_out[0] == 0, "R1", "sclk idle", gpio_out[0], 0);
    check(gpio_out[6:3] == 4'hF, "R1", "chip selects", gpio_out[6:3], 4'hF);
    // R10 default map: pins 0,1,3..6 driven
    check(gpio_oe == 16'h007B, "R10", "default oe", gpio_oe, 16'h007B);

    set_prof(0, 0, 8, 0, 0);
    set_prof(1, 2, 32, 1, 1);
    set_prof(2, 1, 1, 0, 1);
    set_prof(3, 3, 13, 1, 0);

    send(0, 32'h0000_00A5, 32'h0000_003C, 0, 0);
    send(1, 32'hDEAD_BEEF, 32'h1234_5678, 0, 0);
    send(2, 32'h0000_0001, 32'h0000_0001, 0, 0);
    send(3, 32'h0000_1ABC, 32'h0000_0F0F, 0, 0);
    send(0, 32'h0000_005A, 32'h0000_00C3, 1, 0);   // R3 busy reject
    send(1, 32'h8000_0001, 32'hFFFF_FFFF, 0, 1);   // R11 rewrite during transfer
    send(1, 32'h0000_0013, 32'h0000_000A, 0, 0);   // R11 new profile in effect
    send(2, 32'h0000_0000, 32'h0000_0000, 0, 0);

    // R10 remap to other pins
    set_map(0, 10); set_map(1, 11); set_map(2, 12); set_map(3, 13);
    @(negedge clk);
    check(gpio_oe == 16'h2C70, "R10", "remapped oe", gpio_oe, 16'h2C70);
    check(gpio_out[13] == 1, "R10", "moved cs idle", gpio_out[13], 1);
    send(0, 32'h0000_0096, 32'h0000_0069, 0, 0);
    send(3, 32'h0000_0555, 32'h0000_1AAA, 0, 0);
    // R10 conflict: cs3 onto sclk pin, lower index (sclk, idle 0) wins
    set_map(6, 10);
    @(negedge clk);
    check(gpio_out[10] == 0, "R10", "shared pin priority", gpio_out[10], 0);
    check(gpio_oe[6] == 0, "R10", "vacated pin undriven", gpio_oe[6], 0);
    set_map(6, 6);
    @(negedge clk);
    check(gpio_out[6] == 1 && gpio_oe[6] == 1, "R10", "restored cs pin",
          {gpio_oe[6], gpio_out[6]}, 2'b11);

    repeat (4) @(negedge clk);
    check(q.size() == 0, "R9", "pending expectations", q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule